// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point words and returns one registered result word with three exception flags. Each word holds a sign bit, an 8-bit exponent stored with an offset of 127, and a 23-bit fraction. Normal values carry an implied leading one. An exponent field of zero with a nonzero fraction encodes a subnormal value: it has no implied one and its scale is 2^-126.

A request is taken when `in_valid` and `in_ready` are both high. One clock edge later the result appears with `out_valid` high, and it stays there unchanged until `out_ready` takes it. In one combinational pass the block orders the two operands by magnitude. It shifts the smaller significand right by the exponent gap and keeps guard, round and sticky positions below the last kept bit. It adds or subtracts the significands, then renormalises the result in either direction, stopping at the subnormal floor. It rounds to nearest with ties to even and renormalises again if rounding carries out.

Top module: `fp32_adder`

## Requirements
- R1: For finite operands, `out_res` equals the exact value of a+b (when `in_sub`=0) or a-b (when `in_sub`=1), rounded to nearest. Bit 31 is the sign, bits 30:23 the biased exponent and bits 22:0 the fraction.
- R2: Bits that alignment shifts below the kept significand take part in rounding. Below half a unit in the last place the result truncates, above half it rounds up, and on an exact half it rounds to the neighbour whose last fraction bit is 0.
- R3: A finite result whose rounded exponent reaches 255 is returned as infinity of the result's sign (exponent field all ones, fraction 0), with `out_ovf`=1.
- R4: A zero significand result has exponent field 0. Equal magnitudes with opposite effective signs give +0 (0x00000000). Two zeros of the same effective sign keep that sign.
- R5: Subnormal operands are accepted. A nonzero result below 2^-126 is returned as a subnormal (exponent field 0) with `out_udf`=1.
- R6: If either operand is a NaN (exponent 255, fraction nonzero), the result is the quiet NaN 0x7FC00000 with all flags 0.
- R7: Infinities of opposite effective sign give 0x7FC00000 with `out_inv`=1. Any other sum that involves an infinity returns that infinity with no flag.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready`=0 and the result and flags hold steady. A request accepted at a clock edge is presented with `out_valid`=1 after that edge.
- R9: After reset `out_valid`=0 and `in_ready`=1.
- R10: When rounding carries out of the significand, the result shifts right once more and its exponent rises by one.
- R11: `in_sub`=1 inverts the sign of operand B before the operation, NaN inputs excepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_sub | input | 1 | 1 = subtract B from A, 0 = add |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 32 | Result word |
| out_ovf | output | 1 | Overflow to infinity |
| out_udf | output | 1 | Subnormal nonzero result |
| out_inv | output | 1 | Invalid operation (opposite infinities) |

## Verification
The datapath holds no state between requests, so any error in the alignment shift, the sticky reduction, the leading-zero count or the rounding carry shows up in the result word presented at the very next edge. Such an error usually moves only the last fraction bit or the exponent, and it does so only for certain exponent gaps and cancellation depths. For that reason the stimulus pairs exponents that lie close together and places operands at the subnormal floor and near the top of the range. A fault in the output register or the handshake shows instead as a result word that changes, or an `in_ready` that rises, while a held result waits for `out_ready`.

// File: rtl/fp32_adder.sv
module fp32_adder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_a,
  input  logic [31:0] in_b,
  input  logic        in_sub,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_res,
  output logic        out_ovf,
  output logic        out_udf,
  output logic        out_inv
);
  localparam int EW = 8;
  localparam int FW = 23;
  localparam int MW = FW + 1;
  localparam int XW = MW + 3;
  localparam int SHW = 2 * MW + 2;
  localparam int MAXSH = SHW - 2;
  localparam logic [31:0] QNAN = 32'h7FC0_0000;
  localparam logic [EW-1:0] EMAX = {EW{1'b1}};

  logic sgn_a, sgn_b;
  logic a_nan, b_nan, a_inf, b_inf;
  logic swap;
  logic [30:0] mag_l, mag_s;
  logic sgn_l, sgn_s;
  logic [9:0] exp_l, exp_s, gap;
  logic [MW-1:0] sig_l, sig_s;
  logic [SHW-1:0] shifted;
  logic [XW-1:0] big_x, small_x;
  logic [XW:0] raw;
  logic [4:0] lzc;
  logic [9:0] lsh;
  logic [XW-1:0] nrm;
  logic [9:0] exp_n, exp_r;
  logic rnd_up;
  logic [MW:0] sig_r;
  logic [MW-1:0] sig_f;
  logic [31:0] res_d;
  logic ovf_d, udf_d, inv_d;

  assign sgn_a = in_a[31];
  assign sgn_b = in_b[31] ^ in_sub;
  assign a_nan = (in_a[30:23] == EMAX) && (in_a[22:0] != '0);
  assign b_nan = (in_b[30:23] == EMAX) && (in_b[22:0] != '0);
  assign a_inf = (in_a[30:23] == EMAX) && (in_a[22:0] == '0);
  assign b_inf = (in_b[30:23] == EMAX) && (in_b[22:0] == '0);

  assign swap  = in_b[30:0] > in_a[30:0];
  assign mag_l = swap ? in_b[30:0] : in_a[30:0];
  assign mag_s = swap ? in_a[30:0] : in_b[30:0];
  assign sgn_l = swap ? sgn_b : sgn_a;
  assign sgn_s = swap ? sgn_a : sgn_b;

  assign exp_l = (mag_l[30:23] == '0) ? 10'd1 : {2'b00, mag_l[30:23]};
  assign exp_s = (mag_s[30:23] == '0) ? 10'd1 : {2'b00, mag_s[30:23]};
  assign sig_l = {mag_l[30:23] != '0, mag_l[22:0]};
  assign sig_s = {mag_s[30:23] != '0, mag_s[22:0]};
  assign gap   = exp_l - exp_s;

  assign shifted = {sig_s, {(SHW-MW){1'b0}}} >> ((gap > MAXSH) ? MAXSH : gap);
  assign small_x = {shifted[SHW-1:SHW-MW-2], |shifted[SHW-MW-3:0]};
  assign big_x   = {sig_l, 3'b000};
  assign raw     = (sgn_l ^ sgn_s) ? ({1'b0, big_x} - {1'b0, small_x})
                                   : ({1'b0, big_x} + {1'b0, small_x});

  always_comb begin
    lzc = 5'(XW);
    for (int i = 0; i < XW; i++)
      if (raw[i]) lzc = 5'(XW - 1 - i);
  end

  always_comb begin
    lsh = '0;
    if (raw[XW]) begin
      nrm   = {raw[XW:2], raw[1] | raw[0]};
      exp_n = exp_l + 10'd1;
    end else begin
      lsh   = ({5'd0, lzc} < (exp_l - 10'd1)) ? {5'd0, lzc} : (exp_l - 10'd1);
      nrm   = raw[XW-1:0] << lsh;
      exp_n = exp_l - lsh;
    end
  end

  assign rnd_up = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
  assign sig_r  = {1'b0, nrm[XW-1:3]} + {{MW{1'b0}}, rnd_up};
  assign sig_f  = sig_r[MW] ? sig_r[MW:1] : sig_r[MW-1:0];
  assign exp_r  = sig_r[MW] ? exp_n + 10'd1 : exp_n;

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    udf_d = 1'b0;
    inv_d = 1'b0;
    if (a_nan || b_nan) begin
      res_d = QNAN;
    end else if (a_inf && b_inf) begin
      if (sgn_a != sgn_b) begin
        res_d = QNAN;
        inv_d = 1'b1;
      end else begin
        res_d = {sgn_a, EMAX, 23'd0};
      end
    end else if (a_inf) begin
      res_d = {sgn_a, EMAX, 23'd0};
    end else if (b_inf) begin
      res_d = {sgn_b, EMAX, 23'd0};
    end else if (raw == '0) begin
      res_d = {sgn_l & sgn_s, 31'd0};
    end else if (exp_r >= {2'b00, EMAX}) begin
      res_d = {sgn_l, EMAX, 23'd0};
      ovf_d = 1'b1;
    end else begin
      res_d = {sgn_l, sig_f[MW-1] ? exp_r[EW-1:0] : {EW{1'b0}}, sig_f[FW-1:0]};
      udf_d = ~sig_f[MW-1];
    end
  end

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_ovf   <= 1'b0;
      out_udf   <= 1'b0;
      out_inv   <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_res   <= res_d;
      out_ovf   <= ovf_d;
      out_udf   <= udf_d;
      out_inv   <= inv_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fp32_adder_chk.sv
module fp32_adder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_res,
  input logic        out_ovf,
  input logic        out_udf,
  input logic        out_inv
);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_ovf)
                                && $stable(out_udf) && $stable(out_inv));

  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r8_fire: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r3_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> out_res[30:0] == 31'h7F80_0000);

  a_r5_udf_sub: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_udf |-> out_res[30:23] == 8'd0 && out_res[22:0] != 23'd0);

  a_r7_inv_nan: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_inv |-> out_res == 32'h7FC0_0000);

  a_r4_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_ovf, out_udf, out_inv}) <= 1);
endmodule

bind fp32_adder fp32_adder_chk chk_i (.*);

// File: tb/fp32_adder_tb_top.sv
module fp32_adder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sub = 1'b0, out_ready = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid, out_ovf, out_udf, out_inv;
  logic [31:0] out_res;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_adder dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_ovf(out_ovf), .out_udf(out_udf), .out_inv(out_inv));

  // returns {inv, udf, ovf, res}
  function automatic logic [34:0] model(input logic [31:0] a, input logic [31:0] b, input logic sub);
    logic sa, sb, sg, ia, ib, na, nb;
    logic [289:0] xa, xb, mag, m, rem, half;
    int ea, eb, p, sh, e;
    sa = a[31]; sb = b[31] ^ sub;
    na = a[30:23] == 8'hFF && a[22:0] != 0; nb = b[30:23] == 8'hFF && b[22:0] != 0;
    ia = a[30:23] == 8'hFF && a[22:0] == 0; ib = b[30:23] == 8'hFF && b[22:0] == 0;
    if (na || nb) return {3'b000, 32'h7FC00000};
    if (ia && ib) return (sa != sb) ? {3'b100, 32'h7FC00000} : {3'b000, sa, 8'hFF, 23'd0};
    if (ia) return {3'b000, sa, 8'hFF, 23'd0};
    if (ib) return {3'b000, sb, 8'hFF, 23'd0};
    ea = (a[30:23] == 0) ? 1 : int'(a[30:23]);
    eb = (b[30:23] == 0) ? 1 : int'(b[30:23]);
    xa = 290'({a[30:23] != 0, a[22:0]}) << (ea - 1);
    xb = 290'({b[30:23] != 0, b[22:0]}) << (eb - 1);
    if (sa == sb) begin mag = xa + xb; sg = sa; end
    else if (xa >= xb) begin mag = xa - xb; sg = sa; end
    else begin mag = xb - xa; sg = sb; end
    if (mag == 0) return {3'b000, sa & sb, 31'd0};
    p = 0;
    for (int i = 0; i < 290; i++) if (mag[i]) p = i;
    if (p <= 23) return {1'b0, ~mag[23], 1'b0, sg, mag[30:0]};
    sh = p - 23;
    m = mag >> sh;
    rem = mag - (m << sh);
    half = 290'd1 << (sh - 1);
    if (rem > half || (rem == half && m[0])) m = m + 1;
    if (m[24]) begin m = m >> 1; sh++; end
    e = sh + 1;
    if (e >= 255) return {3'b001, sg, 8'hFF, 23'd0};
    return {3'b000, sg, 8'(e), m[22:0]};
  endfunction

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got {inv,udf,ovf,res}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic sub, input string tag);
    logic [34:0] exp;
    exp = model(a, b, sub);
    @(negedge clk);
    in_a = a; in_b = b; in_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_inv, out_udf, out_ovf, out_res}, exp);
    if (!out_valid) check({tag, " valid"}, 35'd0, 35'd1);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  function automatic string tag_of(input logic [31:0] a, input logic [31:0] b, input logic [34:0] e);
    if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0)) return "R6";
    if (a[30:23] == 8'hFF || b[30:23] == 8'hFF) return "R7";
    if (e[32]) return "R3";
    if (e[30:0] == 0) return "R4";
    if (e[33] || a[30:23] == 0 || b[30:23] == 0) return "R5";
    return "R1";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, held;
    logic [34:0] e;
    int unsigned seed;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9 reset", {33'd0, out_valid, in_ready}, 35'd1);
    rst_n = 1'b1;

    run_op(32'h3F800000, 32'h3F800000, 1'b0, "R1 1+1");
    run_op(32'h3F000000, 32'h3EE00000, 1'b1, "R11 0.5-0.4375");
    run_op(32'h3F800000, 32'h3F800000, 1'b1, "R4 x-x");
    run_op(32'h80000000, 32'h00000000, 1'b1, "R4 -0-0");
    run_op(32'hC0400000, 32'h40400000, 1'b0, "R4 -3+3");
    run_op(32'h3F800000, 32'h33800000, 1'b0, "R2 tie even down");
    run_op(32'h3F800001, 32'h33800000, 1'b0, "R2 tie odd up");
    run_op(32'h3F800000, 32'h33800001, 1'b0, "R2 above half");
    run_op(32'h3F800000, 32'h33000000, 1'b0, "R2 below half");
    run_op(32'h3F800000, 32'h00000001, 1'b1, "R2 sticky far");
    run_op(32'h3FFFFFFF, 32'h33800000, 1'b0, "R10 carry");
    run_op(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R3 max+max");
    run_op(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, "R3 neg overflow");
    run_op(32'h7F7FFFFF, 32'h73000000, 1'b0, "R3 round to inf");
    run_op(32'h00000003, 32'h00000001, 1'b0, "R5 sub+sub");
    run_op(32'h00800000, 32'h00000001, 1'b1, "R5 below min normal");
    run_op(32'h007FFFFF, 32'h00000001, 1'b0, "R5 sub to normal");
    run_op(32'h7FC00000, 32'h3F800000, 1'b0, "R6 qnan");
    run_op(32'h3F800000, 32'h7F800001, 1'b1, "R6 snan");
    run_op(32'h7F800000, 32'h7F800000, 1'b1, "R7 inf-inf");
    run_op(32'hFF800000, 32'h7F800000, 1'b0, "R7 -inf+inf");
    run_op(32'h7F800000, 32'hC2000000, 1'b0, "R7 inf+x");
    run_op(32'h3F800000, 32'h7F800000, 1'b1, "R11 x-inf");

    @(negedge clk);
    in_a = 32'h40000000; in_b = 32'h40400000; in_sub = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_a = 32'h3F800000;
    held = out_res;
    repeat (3) @(negedge clk);
    check("R8 hold", {2'd0, out_valid, in_ready, out_res}, {2'd0, 1'b1, 1'b0, held});
    check("R8 value", {3'd0, out_res}, {3'd0, 32'h40A00000});
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R8 drain", {33'd0, out_valid, in_ready}, 35'd1);

    for (int n = 0; n < 1500; n++) begin
      seed = $urandom;
      if (seed[1:0] == 2'd0) begin
        a = $urandom; b = $urandom;
      end else begin
        a = $urandom; b = $urandom;
        case (seed[4:2])
          3'd0: b[30:23] = a[30:23];
          3'd1: b[30:23] = a[30:23] + 8'd1;
          3'd2: b[30:23] = a[30:23] - 8'(seed[10:8]);
          3'd3: begin a[30:23] = 8'(seed[9:8]); b[30:23] = 8'(seed[11:10]); end
          3'd4: begin a[30:23] = 8'hFE - 8'(seed[9:8]); b[30:23] = 8'hFE - 8'(seed[11:10]); end
          3'd5: begin b[30:0] = a[30:0]; b[5:0] = 6'(seed[17:12]); end
          default: b[30:23] = a[30:23] - 8'(seed[13:8] % 30);
        endcase
      end
      e = model(a, b, seed[31]);
      run_op(a, b, seed[31], tag_of(a, b, e));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule